// File: doc/BRIEF.md
# Sequential Booth Multiplier

This block multiplies two 36-bit two's-complement words over a series of clock cycles. It uses radix-2 Booth recoding. A one-cycle `start` captures the multiplier, the multiplicand and the result mode. The block then walks the multiplier from its least significant bit upward, one bit pair at a time. For each pair it adds the multiplicand into an accumulator, subtracts it, or leaves the accumulator alone. After that it shifts the accumulator/multiplier pair one place right. A step counter runs from a preset value to all-ones and bounds the loop. A last step shifts only the low word, so the low word carries a copy of the high word's sign in its top bit.

There are two result modes. Double mode returns a high word and a low word, and overflow there means the one product that cannot be represented. Single mode returns only the low word and flags overflow whenever the product does not fit in 36 bits. The results and the overflow flag are registered. They change only in the cycle in which `done` pulses, and they hold until the next result.

Bit numbering in this document is LSB = bit 0. P denotes the exact 72-bit signed product of `multiplicand` and `multiplier`.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst_n` is low, `done`, `ovf`, `prod_hi` and `prod_lo` are all zero.
- R2: In double mode (`single_word`=0 at start), `prod_hi` = P[70:35] and `prod_lo` = {P[70], P[34:0]}.
- R3: In double mode, `ovf` is 1 exactly when both operands are negative and `prod_hi` bit 35 is set. This happens only for −2^35 × −2^35.
- R4: In single mode (`single_word`=1 at start), `prod_lo` = {P[70], P[34:0]}, `prod_hi` is zero, and `ovf` is 1 exactly when P lies outside −2^35 … 2^35−1.
- R5: Count the edge that accepts `start` as edge 0. `done` is high for exactly one cycle, after edge 37+A. A is the number of positions i (0…35) at which multiplier bit i differs from bit i−1, with bit −1 taken as 0.
- R6: A `start` that arrives while an operation is in progress, including its final cycle, has no effect on the result, the overflow flag or the timing of `done`.
- R7: `prod_hi`, `prod_lo` and `ovf` change only in cycles in which `done` is high.
- R8: The 9-bit step counter is zero when idle. It becomes 9'o734 by OR at start, leaves the loop at 9'o777, and is cleared by the last step.
- R9: Operands and mode are captured at the accepting edge. Later changes on those inputs do not affect the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| single_word | input | 1 | 1 = single-word result with fit check, 0 = double-word result |
| multiplier | input | 36 | Multiplier operand, two's complement |
| multiplicand | input | 36 | Multiplicand operand, two's complement |
| done | output | 1 | One-cycle pulse when results are valid |
| prod_hi | output | 36 | High product word (zero in single mode) |
| prod_lo | output | 36 | Low product word |
| ovf | output | 1 | Overflow for the last operation |

## Verification
Suppose the step counter, the history bit or the add/subtract choice goes wrong. Either the `done` pulse then moves away from the 37+A cycle that follows from the multiplier's bit transitions, or the product words no longer match the 72-bit reference. Both show up within one operation, at most 74 cycles after start. The bench predicts `done` and every output bit for every cycle. A missed capture, a start that leaks into a running operation, or an output register that updates outside the done cycle is therefore reported in the first cycle it differs. The operand sets include −2^35 in either position, all-ones, zero and alternating bit patterns. Together they drive the accumulator to its extremes and give the largest number of add/subtract steps.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_EVAL,
      ST_POST,
      ST_FIN
   } mul_state_t;

   typedef enum logic [2:0] {
      CMD_HOLD,
      CMD_LOAD,
      CMD_ARITH,
      CMD_SHIFT,
      CMD_LAST,
      CMD_FINISH
   } mul_cmd_t;

   typedef enum logic [1:0] {
      OP_PASS,
      OP_ADD,
      OP_SUB
   } step_op_t;

endpackage

// File: rtl/booth_step_unit.sv
module booth_step_unit
   import booth_mul_pkg::*;
#(
   parameter int W          = 36,
   parameter bit SUB_INVERT = 1'b1
) (
   input  logic [W:0]   acc,
   input  logic [W-1:0] mcand,
   input  logic         mq_lsb,
   input  logic         hist,
   output logic [W:0]   acc_next,
   output logic         differs
);
   localparam int AW = W + 1;

   logic [AW-1:0] ext;
   step_op_t      op;

   assign ext     = {mcand[W-1], mcand};
   assign differs = mq_lsb ^ hist;

   always_comb begin
      unique case ({mq_lsb, hist})
         2'b01:   op = OP_ADD;
         2'b10:   op = OP_SUB;
         default: op = OP_PASS;
      endcase
   end

   generate
      if (SUB_INVERT) begin : g_inv
         logic [AW-1:0] operand;
         logic [AW-1:0] carry_in;
         always_comb begin
            operand  = (op == OP_SUB) ? ~ext : ext;
            carry_in = {{(AW-1){1'b0}}, (op == OP_SUB)};
            acc_next = (op == OP_PASS) ? acc : acc + operand + carry_in;
         end
      end else begin : g_direct
         always_comb begin
            case (op)
               OP_ADD:  acc_next = acc + ext;
               OP_SUB:  acc_next = acc - ext;
               default: acc_next = acc;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
   import booth_mul_pkg::*;
#(
   parameter int                CNT_W  = 9,
   parameter logic [CNT_W-1:0] PRESET = 9'o734
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             differs,
   output mul_cmd_t         cmd,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] LAST = '1;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   mul_state_t       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      cmd     = CMD_HOLD;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               cmd     = CMD_LOAD;
               cnt_d   = cnt_q | PRESET;
               state_d = ST_EVAL;
            end
         end
         ST_EVAL: begin
            if (differs) begin
               cmd     = CMD_ARITH;
               state_d = ST_POST;
            end else if (cnt_q == LAST) begin
               cmd     = CMD_LAST;
               cnt_d   = '0;
               state_d = ST_FIN;
            end else begin
               cmd   = CMD_SHIFT;
               cnt_d = cnt_q + ONE;
            end
         end
         ST_POST: begin
            if (cnt_q == LAST) begin
               cmd     = CMD_LAST;
               cnt_d   = '0;
               state_d = ST_FIN;
            end else begin
               cmd     = CMD_SHIFT;
               cnt_d   = cnt_q + ONE;
               state_d = ST_EVAL;
            end
         end
         ST_FIN: begin
            cmd     = CMD_FINISH;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/booth_result_form.sv
module booth_result_form #(
   parameter int W = 36
) (
   input  logic [W-1:0] acc_hi,
   input  logic [W-1:0] mq,
   input  logic         single,
   input  logic         both_neg,
   output logic [W-1:0] res_hi,
   output logic [W-1:0] res_lo,
   output logic         res_ov
);
   logic [W-1:0] folded;
   logic         ov_single, ov_double;

   assign folded    = acc_hi[W-1] ? ~acc_hi : acc_hi;
   assign ov_single = |folded;
   assign ov_double = both_neg & acc_hi[W-1];

   assign res_hi = single ? '0 : acc_hi;
   assign res_lo = mq;
   assign res_ov = single ? ov_single : ov_double;

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_mul_pkg::*;
#(
   parameter int                W          = 36,
   parameter int                CNT_W      = 9,
   parameter logic [CNT_W-1:0] PRESET     = 9'o734,
   parameter bit                SUB_INVERT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         single_word,
   input  logic [W-1:0] multiplier,
   input  logic [W-1:0] multiplicand,
   output logic         done,
   output logic [W-1:0] prod_hi,
   output logic [W-1:0] prod_lo,
   output logic         ovf
);
   localparam int STEPS = (2 ** CNT_W) - 1 - int'(PRESET);

   generate
      if (W < 2) begin : g_bad_width
         $error("booth_seq_mul: W must be at least 2");
      end
      if (STEPS != W - 1) begin : g_bad_preset
         $error("booth_seq_mul: counter preset must leave exactly W-1 shifts");
      end
   endgenerate

   mul_cmd_t         cmd;
   logic [CNT_W-1:0] cnt;
   logic [W:0]       ar_q, acc_next;
   logic [W-1:0]     mq_q, mcand_q;
   logic             hist_q, single_q, both_neg_q, differs;
   logic [W-1:0]     fin_hi, fin_lo;
   logic             fin_ov;

   booth_seq_ctrl #(.CNT_W(CNT_W), .PRESET(PRESET)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .differs (differs),
      .cmd     (cmd),
      .cnt     (cnt)
   );

   booth_step_unit #(.W(W), .SUB_INVERT(SUB_INVERT)) u_step (
      .acc      (ar_q),
      .mcand    (mcand_q),
      .mq_lsb   (mq_q[0]),
      .hist     (hist_q),
      .acc_next (acc_next),
      .differs  (differs)
   );

   booth_result_form #(.W(W)) u_form (
      .acc_hi   (ar_q[W-1:0]),
      .mq       (mq_q),
      .single   (single_q),
      .both_neg (both_neg_q),
      .res_hi   (fin_hi),
      .res_lo   (fin_lo),
      .res_ov   (fin_ov)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar_q       <= '0;
         mq_q       <= '0;
         hist_q     <= 1'b0;
         mcand_q    <= '0;
         single_q   <= 1'b0;
         both_neg_q <= 1'b0;
      end else begin
         unique case (cmd)
            CMD_LOAD: begin
               ar_q       <= '0;
               mq_q       <= multiplier;
               hist_q     <= 1'b0;
               mcand_q    <= multiplicand;
               single_q   <= single_word;
               both_neg_q <= multiplier[W-1] & multiplicand[W-1];
            end
            CMD_ARITH: ar_q <= acc_next;
            CMD_SHIFT: begin
               ar_q   <= {ar_q[W], ar_q[W:1]};
               mq_q   <= {ar_q[0], mq_q[W-1:1]};
               hist_q <= mq_q[0];
            end
            CMD_LAST: begin
               mq_q   <= {ar_q[W-1], mq_q[W-1:1]};
               hist_q <= mq_q[0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done    <= 1'b0;
         prod_hi <= '0;
         prod_lo <= '0;
         ovf     <= 1'b0;
      end else begin
         done <= (cmd == CMD_FINISH);
         if (cmd == CMD_FINISH) begin
            prod_hi <= fin_hi;
            prod_lo <= fin_lo;
            ovf     <= fin_ov;
         end
      end
   end

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk
   import booth_mul_pkg::*;
#(
   parameter int                W      = 36,
   parameter int                CNT_W  = 9,
   parameter logic [CNT_W-1:0] PRESET = 9'o734
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic [W-1:0]     prod_hi,
   input logic [W-1:0]     prod_lo,
   input logic             ovf,
   input mul_cmd_t         cmd,
   input logic [CNT_W-1:0] cnt,
   input logic [W-1:0]     mcand_q,
   input logic             single_q
);

   // R5: done is a single-cycle pulse
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: results only move together with done
   p_hold_results_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(ovf)));

   // R8: counter carries the preset right after an accepted start
   p_cnt_preset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LOAD) |=> (cnt == PRESET));

   // R8: last step leaves the counter cleared
   p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LAST) |=> (cnt == '0));

   // R9: captured operand and mode do not move outside a load
   p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_LOAD) |=> ($stable(mcand_q) && $stable(single_q)));

   // R3: double-mode overflow implies the high word's top bit is set
   p_ovf_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !single_q && ovf) |-> prod_hi[W-1]);

   // R4: single mode returns a zero high word
   p_single_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && single_q) |-> (prod_hi == '0));

   // R7: low word stays stable through any non-finishing cycle
   p_lo_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_FINISH) |=> $stable(prod_lo));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(
   .W      (W),
   .CNT_W  (CNT_W),
   .PRESET (PRESET)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .prod_hi  (prod_hi),
   .prod_lo  (prod_lo),
   .ovf      (ovf),
   .cmd      (cmd),
   .cnt      (cnt),
   .mcand_q  (mcand_q),
   .single_q (single_q)
);

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 36;
   localparam int BASE_LAT   = 37;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         single_word = 1'b0;
   logic [W-1:0] multiplier = '0;
   logic [W-1:0] multiplicand = '0;
   logic         done;
   logic [W-1:0] prod_hi, prod_lo;
   logic         ovf;

   int checks = 0;
   int errors = 0;
   bit run_checks = 1'b0;

   // reference model state
   int           m_left = 0;
   bit           m_done = 1'b0;
   bit           m_single = 1'b0;
   logic [W-1:0] m_hi = '0, m_lo = '0;
   bit           m_ov = 1'b0;
   logic [W-1:0] p_hi = '0, p_lo = '0;
   bit           p_ov = 1'b0, p_single = 1'b0;

   booth_seq_mul uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .single_word  (single_word),
      .multiplier   (multiplier),
      .multiplicand (multiplicand),
      .done         (done),
      .prod_hi      (prod_hi),
      .prod_lo      (prod_lo),
      .ovf          (ovf)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int booth_adds(input logic [W-1:0] b);
      int n = 0;
      for (int i = 0; i < W; i++) begin
         logic prev;
         prev = (i == 0) ? 1'b0 : b[i-1];
         if (b[i] != prev) n++;
      end
      return n;
   endfunction

   function automatic void calc(input logic [W-1:0] a, input logic [W-1:0] b, input bit single,
                                output logic [W-1:0] hi, output logic [W-1:0] lo, output bit ov);
      logic signed [2*W-1:0] ea, eb, p, lim_hi, lim_lo, big;
      ea     = {{W{a[W-1]}}, a};
      eb     = {{W{b[W-1]}}, b};
      p      = ea * eb;
      lim_hi = (72'sd1 <<< (W-1)) - 72'sd1;
      lim_lo = -(72'sd1 <<< (W-1));
      big    = 72'sd1 <<< (2*W-2);
      lo     = {p[2*W-2], p[W-2:0]};
      if (single) begin
         hi = '0;
         ov = (p > lim_hi) || (p < lim_lo);
      end else begin
         hi = p[2*W-2:W-1];
         ov = (p == big);
      end
   endfunction

   // behavioural cycle model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_left = 0; m_done = 1'b0; m_hi = '0; m_lo = '0; m_ov = 1'b0;
      end else begin
         m_done = 1'b0;
         if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
               m_done = 1'b1; m_hi = p_hi; m_lo = p_lo; m_ov = p_ov; m_single = p_single;
            end
         end else if (start) begin
            calc(multiplicand, multiplier, single_word, p_hi, p_lo, p_ov);
            p_single = single_word;
            m_left   = BASE_LAT + booth_adds(multiplier);
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && run_checks) begin
         chk(done === m_done, "R5 R8 done timing", {71'd0, done}, {71'd0, m_done});
         if (m_done) begin
            chk(prod_hi === m_hi, m_single ? "R4 high word" : "R2 high word", {36'd0, prod_hi}, {36'd0, m_hi});
            chk(prod_lo === m_lo, m_single ? "R4 low word" : "R2 low word", {36'd0, prod_lo}, {36'd0, m_lo});
            chk(ovf === m_ov, m_single ? "R4 overflow" : "R3 overflow", {71'd0, ovf}, {71'd0, m_ov});
         end else begin
            chk(prod_hi === m_hi && prod_lo === m_lo && ovf === m_ov, "R7 hold",
                {prod_hi, prod_lo}, {m_hi, m_lo});
         end
      end
   end

   task automatic go(input logic [W-1:0] b, input logic [W-1:0] a, input bit single);
      while (m_left != 0) @(negedge clk);
      multiplier = b; multiplicand = a; single_word = single; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (m_left != 0) @(negedge clk);
   endtask

   task automatic go_disturbed(input logic [W-1:0] b, input logic [W-1:0] a, input bit single);
      logic [W-1:0] e_hi, e_lo;
      bit e_ov;
      calc(a, b, single, e_hi, e_lo, e_ov);
      while (m_left != 0) @(negedge clk);
      multiplier = b; multiplicand = a; single_word = single; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      multiplier = ~b; multiplicand = a ^ 36'h0F0F0F0F0; single_word = !single;   // R9
      repeat (5) @(negedge clk);
      start = 1'b1;                                                             // R6 mid-run
      @(negedge clk);
      start = 1'b0;
      while (m_left != 1) @(negedge clk);
      start = 1'b1;                                                             // R6 final cycle
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1, "R6 done after ignored starts", {71'd0, done}, 72'd1);
      chk(prod_lo === e_lo, "R6 R9 low word", {36'd0, prod_lo}, {36'd0, e_lo});
      chk(prod_hi === e_hi, "R9 high word", {36'd0, prod_hi}, {36'd0, e_hi});
      chk(ovf === e_ov, "R9 overflow", {71'd0, ovf}, {71'd0, e_ov});
      @(negedge clk);
      chk(done === 1'b0, "R6 no extra done", {71'd0, done}, 72'd0);
   endtask

   localparam logic [W-1:0] MINV = 36'h800000000;
   localparam logic [W-1:0] MAXV = 36'h7FFFFFFFF;
   localparam logic [W-1:0] ONES = 36'hFFFFFFFFF;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(done === 1'b0 && ovf === 1'b0, "R1 flags in reset", {70'd0, done, ovf}, 72'd0);
      chk(prod_hi === '0 && prod_lo === '0, "R1 words in reset", {prod_hi, prod_lo}, 72'd0);
      rst_n = 1'b1;
      run_checks = 1'b1;
      @(negedge clk);

      for (int m = 0; m < 2; m++) begin
         go(36'd0, 36'd0, m[0]);
         go(ONES, ONES, m[0]);
         go(MINV, MINV, m[0]);
         go(36'd1, MINV, m[0]);
         go(MINV, 36'd1, m[0]);
         go(MAXV, MAXV, m[0]);
         go(ONES, MINV, m[0]);
         go(MINV, MAXV, m[0]);
         go(36'h555555555, 36'hAAAAAAAAA, m[0]);
         go(36'hAAAAAAAAA, 36'h555555555, m[0]);
         go(36'd12345, ONES, m[0]);
         go(36'h00003FFFF, 36'h000020000, m[0]);
      end

      go_disturbed(36'h123456789, 36'hFEDCBA987, 1'b0);
      go_disturbed(MINV, MINV, 1'b1);
      go_disturbed(36'h555555555, 36'd7, 1'b1);

      for (int n = 0; n < 160; n++) begin
         logic [W-1:0] ra, rb;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         if (n % 4 == 1) ra = ra >>> 20;
         if (n % 4 == 2) rb = {{20{rb[W-1]}}, rb[15:0]};
         go(rb, ra, n[0]);
      end

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule